// File: doc/BRIEF.md
# System Control Register Bank with Decode-Error Interrupt

This block is a bank of 32-bit control and configuration words on a simple word-aligned, byte-addressed read/write port. A write is taken on the rising clock edge when `busWrite` is high. Read data is combinational from `busAddr`. The bank holds the following words:

- plain storage words: a write-protect word, a control word, a spare word, sixteen scratch words, four safety-check words and the repair data words;
- configuration words whose reserved bits are masked;
- read-only words driven from input pins: a presence strap, a repair status word and eight repair test-data words;
- one interrupt source with a status bit, a mask bit and three command words (unmask, mask and set).

The single level interrupt `irqOut` is high while the status bit is set and its mask bit is clear. The mask cannot be written directly. Software raises the status bit through the set command, clears it by writing a 1 to the status word, and moves the mask only through the unmask and mask command words. The window covers 83 words (byte offsets 0x000 to 0x148). Anything else reads as zero and ignores writes.

Top module: `ctrl_reg_bank`

## Requirements
- R1: A synchronous active-low reset sets every stored bit to zero and the mask word (offset 0x0C) to 0x1. After reset, `irqOut` is low.
- R2: The following words store and return all 32 bits of the last write: 0x00, 0x04, 0x1C, 0x20..0x5C, 0x60..0x6C, 0x74, 0x104 and 0x10C..0x128. Each word is independent of the others.
- R3: Reserved bits read zero and keep nothing. The words 0x78, 0x7C and 0x80 keep bits 7:0. The word 0x88 keeps bits 3:0. The word 0x100 keeps every bit except bits 3:1.
- R4: The following read-only bits ignore writes and read their input pins:
  - 0x8C bit 0 reads `presenceIn`, and its other bits read zero.
  - 0x108 bits 3:0 read `repStatIn[3:0]`, bit 30 reads `repStatIn[4]` and bit 31 reads `repStatIn[5]`. Its bits 29:4 are plain storage.
  - The word at 0x12C+4k reads `testDataIn[32k+31:32k]`, for k = 0 to 7.
- R5: Status word 0x08 bit 0 is cleared by writing 1 to it. Writing 0 leaves it unchanged.
- R6: Writes to the mask word 0x0C have no effect. Writing a 1 in bit 0 to 0x10 clears the mask bit. Writing a 1 in bit 0 to 0x14 sets it.
- R7: Writing a 1 in bit 0 to 0x18 sets the status bit. The words 0x10, 0x14 and 0x18 always read zero.
- R8: `irqOut` equals (status bit AND NOT mask bit), updated in the cycle after any write that changes either bit.
- R9: Unmapped offsets read zero and ignore writes. These are 0x70, 0x84, 0x90..0xFC and everything from 0x14C upward. An access whose address bits 1:0 are not zero reads zero and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| busWrite | input | 1 | Write strobe, taken on the rising edge |
| busAddr | input | ADDR_W | Byte address of the access |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr (combinational) |
| presenceIn | input | 1 | Presence strap, read at 0x8C bit 0 |
| repStatIn | input | 6 | Repair status inputs {bit31, bit30, bits 3:0} |
| testDataIn | input | 256 | Eight repair test-data words, word k at bits 32k+31:32k |
| irqOut | output | 1 | Level interrupt |

## Verification
The bench writes several patterns to all 128 word slots of the 9-bit address space, including a pattern that differs for every word. It then reads every slot back against masks computed from the offset map. A decoder that aliases words, leaks reserved bits or stores into read-only or unmapped slots shows up as a mismatched word. Unaligned writes would corrupt the neighbouring aligned word, and the bench reads that word back to catch it. The interrupt sequence covers the following cases: a set while masked (a wrong reset mask would fire `irqOut` early), a direct write to the mask (a writable mask would change the result), a status write of zero (a toggling status would drop the bit), and a write-1 clear while unmasked.

// File: rtl/crb_pkg.sv
package crb_pkg;
  localparam int DATA_W      = 32;
  localparam int IRQ_W       = 1;
  localparam int NUM_SCRATCH = 16;
  localparam int NUM_SAFETY  = 4;
  localparam int NUM_CACHE   = 8;
  localparam int NUM_TEST    = 8;
  localparam int IDX_W       = 7;

  // word indexes (byte offset / 4); the offset map is fixed by software
  localparam int I_ISR        = 2;
  localparam int I_IMR        = 3;
  localparam int I_IER        = 4;
  localparam int I_IDR        = 5;
  localparam int I_ITR        = 6;
  localparam int I_SPARE      = 7;
  localparam int I_SCR0       = 8;
  localparam int I_SAFE_LAST  = I_SCR0 + NUM_SCRATCH + NUM_SAFETY - 1;
  localparam int I_SID0       = 29;
  localparam int I_SID1       = 30;
  localparam int I_SID3       = 32;
  localparam int I_LINK       = 34;
  localparam int I_PRESENT    = 35;
  localparam int I_REPCTL0    = 64;
  localparam int I_REPCTL1    = 65;
  localparam int I_REPSTAT    = 66;
  localparam int I_CACHE0     = 67;
  localparam int I_CACHE_LAST = I_CACHE0 + NUM_CACHE - 1;
  localparam int I_TEST0      = I_CACHE_LAST + 1;
  localparam int WORD_COUNT   = I_TEST0 + NUM_TEST;

  localparam logic [DATA_W-1:0] REPSTAT_RO = 32'hC000_000F;

  typedef struct packed {
    logic             wrPlain;
    logic             wrStat;
    logic             wrEnab;
    logic             wrDisab;
    logic             wrTrig;
    logic             rdOk;
    logic [IDX_W-1:0] idx;
  } strobe_t;

  // bits of a word that hold software-written state
  function automatic logic [DATA_W-1:0] writableMask(int w);
    if (w <= 1 || (w >= I_SPARE && w <= I_SAFE_LAST) || w == I_SID0 ||
        w == I_REPCTL1 || (w >= I_CACHE0 && w <= I_CACHE_LAST))
      return '1;
    if (w >= I_SID1 && w <= I_SID3) return 32'h0000_00FF;
    if (w == I_LINK)    return 32'h0000_000F;
    if (w == I_REPCTL0) return 32'hFFFF_FFF1;
    if (w == I_REPSTAT) return ~REPSTAT_RO;
    return '0;
  endfunction
endpackage

// File: rtl/crb_decode.sv
module crb_decode
  import crb_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           stb
);
  localparam int WORD_AW = ADDR_W - 2;

  logic [WORD_AW-1:0] wordFull;
  logic               aligned;
  logic               inWin;
  logic               wrOk;
  int                 wIdx;

  assign wordFull = busAddr[ADDR_W-1:2];
  assign aligned  = (busAddr[1:0] == 2'b00);
  assign inWin    = (int'(wordFull) < WORD_COUNT);
  assign wrOk     = busWrite && aligned && inWin;
  assign wIdx     = int'(wordFull);

  always_comb begin
    stb         = '0;
    stb.idx     = wordFull[IDX_W-1:0];
    stb.rdOk    = aligned && inWin;
    stb.wrStat  = wrOk && (wIdx == I_ISR);
    stb.wrEnab  = wrOk && (wIdx == I_IER);
    stb.wrDisab = wrOk && (wIdx == I_IDR);
    stb.wrTrig  = wrOk && (wIdx == I_ITR);
    stb.wrPlain = wrOk && !(wIdx >= I_ISR && wIdx <= I_ITR);
  end
endmodule

// File: rtl/crb_regs.sv
module crb_regs
  import crb_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  strobe_t                  stb,
  input  logic [DATA_W-1:0]        busWdata,
  input  logic                     presenceIn,
  input  logic [5:0]               repStatIn,
  input  logic [NUM_TEST*DATA_W-1:0] testDataIn,
  output logic [DATA_W-1:0]        busRdata,
  output logic                     irqOut
);
  logic [DATA_W-1:0] store [WORD_COUNT];
  logic [DATA_W-1:0] view  [WORD_COUNT];
  logic [IRQ_W-1:0]  isr;
  logic [IRQ_W-1:0]  imr;

  // storage words, only the writable bits of each are kept
  for (genvar w = 0; w < WORD_COUNT; w++) begin : g_word
    localparam logic [DATA_W-1:0] WM = writableMask(w);
    if (WM != '0) begin : g_rw
      always_ff @(posedge clk) begin
        if (!rstN)
          store[w] <= '0;
        else if (stb.wrPlain && int'(stb.idx) == w)
          store[w] <= (store[w] & ~WM) | (busWdata & WM);
      end
    end else begin : g_none
      assign store[w] = '0;
    end
  end

  // interrupt status and mask
  always_ff @(posedge clk) begin
    if (!rstN) begin
      isr <= '0;
      imr <= '1;
    end else begin
      if (stb.wrTrig)
        isr <= isr | busWdata[IRQ_W-1:0];
      else if (stb.wrStat)
        isr <= isr & ~busWdata[IRQ_W-1:0];
      if (stb.wrEnab)
        imr <= imr & ~busWdata[IRQ_W-1:0];
      else if (stb.wrDisab)
        imr <= imr | busWdata[IRQ_W-1:0];
    end
  end

  assign irqOut = |(isr & ~imr);

  // read view: stored bits merged with status, mask and pin-driven bits
  always_comb begin
    for (int w = 0; w < WORD_COUNT; w++) view[w] = store[w];
    view[I_ISR]        = {{(DATA_W-IRQ_W){1'b0}}, isr};
    view[I_IMR]        = {{(DATA_W-IRQ_W){1'b0}}, imr};
    view[I_PRESENT][0] = presenceIn;
    view[I_REPSTAT]    = store[I_REPSTAT] |
                         {repStatIn[5], repStatIn[4], 26'b0, repStatIn[3:0]};
    for (int k = 0; k < NUM_TEST; k++)
      view[I_TEST0 + k] = testDataIn[k*DATA_W +: DATA_W];
  end

  assign busRdata = stb.rdOk ? view[stb.idx] : '0;

  p_w1c_clears_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrStat && busWdata[0]) |=> !isr[0]);
  p_trig_sets_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrTrig && busWdata[0]) |=> isr[0]);
  p_enable_unmasks_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrEnab && busWdata[0]) |=> !imr[0]);
  p_disable_masks_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrDisab && busWdata[0]) |=> imr[0]);
  p_mask_holds_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.wrEnab || stb.wrDisab) |=> $stable(imr));
  p_status_holds_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.wrStat || stb.wrTrig) |=> $stable(isr));
  p_link_reserved_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdOk && int'(stb.idx) == I_LINK) |-> busRdata[31:4] == '0);
  p_test_pins_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdOk && int'(stb.idx) == I_TEST0) |-> busRdata == testDataIn[DATA_W-1:0]);
  p_one_strobe_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.wrPlain, stb.wrStat, stb.wrEnab, stb.wrDisab, stb.wrTrig}));
endmodule

// File: rtl/ctrl_reg_bank.sv
module ctrl_reg_bank
  import crb_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          busWrite,
  input  logic [ADDR_W-1:0]             busAddr,
  input  logic [DATA_W-1:0]             busWdata,
  output logic [DATA_W-1:0]             busRdata,
  input  logic                          presenceIn,
  input  logic [5:0]                    repStatIn,
  input  logic [NUM_TEST*DATA_W-1:0]    testDataIn,
  output logic                          irqOut
);
  strobe_t stb;

  crb_decode #(.ADDR_W(ADDR_W)) u_decode (
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .stb      (stb)
  );

  crb_regs u_regs (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .busWdata   (busWdata),
    .presenceIn (presenceIn),
    .repStatIn  (repStatIn),
    .testDataIn (testDataIn),
    .busRdata   (busRdata),
    .irqOut     (irqOut)
  );
endmodule

// File: tb/sim_ctrl_reg_bank.sv
module sim_ctrl_reg_bank;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         busWrite = 1'b0;
  logic [8:0]   busAddr = '0;
  logic [31:0]  busWdata = '0;
  logic [31:0]  busRdata;
  logic         presenceIn = 1'b1;
  logic [5:0]   repStatIn = 6'h2A;
  logic [255:0] testDataIn = '0;
  logic         irqOut;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  logic [31:0] mdl [128];
  logic        isrM, imrM;

  always #10 clk = ~clk;

  ctrl_reg_bank u0 (
    .clk(clk), .rstN(rstN), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .presenceIn(presenceIn),
    .repStatIn(repStatIn), .testDataIn(testDataIn), .irqOut(irqOut)
  );

  function automatic logic [31:0] wmTb(int w);
    if (w == 0 || w == 1 || (w >= 7 && w <= 27) || w == 29 || w == 65 ||
        (w >= 67 && w <= 74)) return 32'hFFFF_FFFF;
    if (w >= 30 && w <= 32) return 32'h0000_00FF;
    if (w == 34) return 32'h0000_000F;
    if (w == 64) return 32'hFFFF_FFF1;
    if (w == 66) return 32'h3FFF_FFF0;
    return 32'h0;
  endfunction

  function automatic logic [31:0] expWord(int w);
    logic [31:0] v;
    if (w >= 83) return 32'h0;
    if (w == 2) return {31'b0, isrM};
    if (w == 3) return {31'b0, imrM};
    if (w >= 4 && w <= 6) return 32'h0;
    v = mdl[w];
    if (w == 35) v[0] = presenceIn;
    if (w == 66) v = v | {repStatIn[5], repStatIn[4], 26'b0, repStatIn[3:0]};
    if (w >= 75) v = testDataIn[(w-75)*32 +: 32];
    return v;
  endfunction

  function automatic string tagFor(int w);
    if (w >= 83 || w == 28 || w == 33 || (w >= 36 && w <= 63)) return "R9";
    if (w == 35 || w == 66 || w >= 75) return "R4";
    if ((w >= 30 && w <= 32) || w == 34 || w == 64) return "R3";
    if (w == 2) return "R5";
    if (w == 3) return "R6";
    if (w >= 4 && w <= 6) return "R7";
    return "R2";
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h (addr %03h)", tag, act, exp, busAddr);
    end
  endtask

  task automatic wr(logic [8:0] a, logic [31:0] d);
    int w;
    @(negedge clk);
    busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWrite = 1'b0;
    w = int'(a[8:2]);
    if (a[1:0] == 2'b00 && w < 83) begin
      if (w == 2) isrM = isrM & ~d[0];
      else if (w == 4 && d[0]) imrM = 1'b0;
      else if (w == 5 && d[0]) imrM = 1'b1;
      else if (w == 6) isrM = isrM | d[0];
      else mdl[w] = (mdl[w] & ~wmTb(w)) | (d & wmTb(w));
    end
  endtask

  task automatic rdChk(logic [8:0] a, string tag);
    @(negedge clk);
    busAddr = a;
    #1;
    chk(tag, busRdata, (a[1:0] == 2'b00) ? expWord(int'(a[8:2])) : 32'h0);
  endtask

  task automatic irqChk(string tag);
    #1;
    chk(tag, {31'b0, irqOut}, {31'b0, isrM & ~imrM});
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    for (int w = 0; w < 128; w++) mdl[w] = 32'h0;
    isrM = 1'b0; imrM = 1'b1;
  endtask

  task automatic sweepAll(string tag);
    for (int w = 0; w < 128; w++)
      rdChk(9'(w * 4), (tag == "") ? tagFor(w) : tag);
  endtask

  task automatic fillAll(int mode);
    for (int w = 0; w < 128; w++) begin
      if (w == 2 || (w >= 4 && w <= 6)) continue;
      case (mode)
        0: wr(9'(w * 4), 32'hFFFF_FFFF);
        1: wr(9'(w * 4), 32'hA5C3_5A3C);
        2: wr(9'(w * 4), (32'(w) * 32'h0103_0507) ^ 32'h9696_9696);
        default: wr(9'(w * 4), 32'h0);
      endcase
    end
  endtask

  initial begin
    for (int k = 0; k < 8; k++)
      testDataIn[k*32 +: 32] = (32'(k) * 32'h1111_0101) ^ 32'hA5A5_0000;
    doReset();

    // reset state
    sweepAll("R1");
    irqChk("R1");

    // pattern sweeps over every slot
    for (int m = 0; m < 4; m++) begin
      fillAll(m);
      sweepAll("");
    end

    // unaligned accesses
    wr(9'h020, 32'h1234_5678);
    wr(9'h074, 32'hCAFE_F00D);
    for (int off = 1; off < 4; off++) begin
      wr(9'(9'h020 + off), 32'hDEAD_BEEF);
      wr(9'(9'h074 + off), 32'h0BAD_0BAD);
      rdChk(9'(9'h020 + off), "R9");
    end
    rdChk(9'h020, "R9");
    rdChk(9'h074, "R9");

    // pin-driven bits follow the inputs
    presenceIn = 1'b0;
    repStatIn  = 6'h15;
    for (int k = 0; k < 8; k++)
      testDataIn[k*32 +: 32] = ~((32'(k) + 32'd3) * 32'h0F0F_1234);
    rdChk(9'h08C, "R4");
    rdChk(9'h108, "R4");
    for (int k = 0; k < 8; k++) rdChk(9'(9'h12C + 4*k), "R4");

    // interrupt sequence
    wr(9'h018, 32'h1);            // set while masked
    rdChk(9'h008, "R7");
    irqChk("R8");
    wr(9'h00C, 32'h0);            // direct mask write ignored
    rdChk(9'h00C, "R6");
    irqChk("R8");
    wr(9'h010, 32'h1);            // unmask
    rdChk(9'h00C, "R6");
    irqChk("R8");
    wr(9'h00C, 32'hFFFF_FFFF);    // direct write ignored
    rdChk(9'h00C, "R6");
    irqChk("R8");
    wr(9'h008, 32'h0);            // zero write keeps status
    rdChk(9'h008, "R5");
    irqChk("R8");
    wr(9'h014, 32'h1);            // mask
    irqChk("R8");
    rdChk(9'h00C, "R6");
    wr(9'h010, 32'h1);
    irqChk("R8");
    wr(9'h008, 32'h1);            // write-1 clear
    rdChk(9'h008, "R5");
    irqChk("R8");
    wr(9'h018, 32'h1);            // set while unmasked
    irqChk("R8");
    wr(9'h018, 32'h1);            // set again
    rdChk(9'h008, "R7");
    rdChk(9'h010, "R7");
    rdChk(9'h014, "R7");
    rdChk(9'h018, "R7");
    wr(9'h008, 32'h1);
    irqChk("R8");

    // reset after activity
    fillAll(0);
    wr(9'h010, 32'h1);
    wr(9'h018, 32'h1);
    doReset();
    sweepAll("R1");
    irqChk("R1");

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule